// File: doc/BRIEF.md
# CAN Arbitration Loss Detector

This block sits beside a CAN transmitter and compares, one bit at a time, the level the node wants to drive with the level it samples back from the bus. The comparison runs only over the arbitration window: start-of-frame, the eleven identifier bits from most significant to least significant, then RTR, then IDE. Dominant is logic 0 and overrides recessive (logic 1) on the wired bus. A node that sends recessive but reads back dominant has been outbid by a higher-priority message. A lower identifier wins, and with equal identifiers a data frame (dominant RTR) wins over a remote frame.

When the node loses, the block raises a loss flag and records the window position where the loss happened. It also forces the node's transmit line recessive for the rest of the frame, so the node carries on as a receiver and the winning frame is not disturbed. A dominant bit sent but read back as recessive inside the window is a different fault. It is reported as a bit error and never as a loss. Bits after IDE are not examined.

The controller supplies a sample strobe per bit time, a frame-start mark that comes with the start-of-frame sample, and a frame-end pulse.

Top module: `can_arb_monitor`

## Requirements
- R1: After reset, `arb_lost`, `rx_only`, `bit_err` and `lost_idx` are 0 and `tx_out` equals `tx_bit`. No comparison is made until a strobe that carries `frame_start`.
- R2: The strobe that carries `frame_start` is window position 0 (start-of-frame). The following strobes are positions 1 to 11 (identifier bit 10 down to bit 0), then 12 (RTR) and 13 (IDE). Clock cycles without `sample_en` do not advance the position.
- R3: A strobe inside the window with `tx_bit`=1 and `rx_bit`=0 sets `arb_lost` at that clock edge.
- R4: On a loss, `lost_idx` takes the window position (0 to 13) of the losing strobe.
- R5: From the cycle after a loss until `frame_end`, `rx_only` is 1 and `tx_out` is 1, whatever `tx_bit` is.
- R6: `arb_lost` and `lost_idx` hold until the next `frame_start` strobe. After a loss, later mismatches in the same frame change neither of them and do not set `bit_err`.
- R7: A strobe inside the window, before any loss, with `tx_bit`=0 and `rx_bit`=1 sets `bit_err` and leaves `arb_lost` at 0. `bit_err` holds until the next `frame_start` strobe.
- R8: Strobes after position 13 (IDE) never set `arb_lost` or `bit_err`.
- R9: `frame_end` clears `rx_only` and ends the window. A `frame_start` strobe clears `arb_lost`, `bit_err` and `lost_idx`, then evaluates its own start-of-frame bit.
- R10: Against a competing frame, the node loses at the first identifier position, counted from the most significant bit, where its bit is 1 and the competitor's is 0. With equal identifiers, a remote frame loses to a data frame at position 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | One-cycle strobe at each bit sample point |
| frame_start | input | 1 | Marks the strobe that samples start-of-frame |
| frame_end | input | 1 | Pulse at the end of the frame |
| tx_bit | input | 1 | Bit the node intends to send (0 = dominant) |
| rx_bit | input | 1 | Bit sampled from the bus |
| tx_out | output | 1 | Bit driven toward the bus, forced recessive after a loss |
| arb_lost | output | 1 | Arbitration lost in the current frame |
| rx_only | output | 1 | Node has been moved to receive-only for the frame |
| lost_idx | output | 4 | Window position of the loss |
| bit_err | output | 1 | Dominant sent but recessive read back inside the window |

## Verification
Two modelled nodes share a wired-AND bus. Random identifier and RTR pairs are mixed with directed pairs: identifiers that differ only in the most significant bit or only in the least significant bit, equal identifiers with a data frame against a remote frame (either side), and fully identical frames. Together these tell apart a loss reported at the right position from one reported off by a bit, or for the wrong side. Idle gaps between strobes show that only strobes advance the position. Mismatches injected after IDE and after a loss must change nothing. A bus bit forced recessive under a dominant send must give a bit error and not a loss. Strobes sent outside a frame, whether before the first `frame_start` or after `frame_end`, show that no comparison runs there.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  localparam int DEF_ID_W = 11;

  // window length: start-of-frame + identifier + RTR + IDE
  function automatic int arb_len(input int id_w);
    return id_w + 3;
  endfunction

  typedef enum logic [1:0] {
    CMP_MATCH  = 2'd0,
    CMP_LOST   = 2'd1,
    CMP_BITERR = 2'd2
  } cmp_kind_e;
endpackage

// File: rtl/can_arb_pos.sv
module can_arb_pos #(
  parameter int ARB_BITS = 14,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic             frame_start,
  input  logic             frame_end,
  output logic [IDX_W-1:0] pos_cur,
  output logic             in_win
);
  localparam logic [IDX_W-1:0] IDLE = IDX_W'(ARB_BITS);

  logic [IDX_W-1:0] pos_q;
  logic             sof_hit;

  assign sof_hit = sample_en && frame_start;
  assign pos_cur = sof_hit ? '0 : pos_q;
  assign in_win  = sof_hit || (sample_en && !frame_end && (pos_q < IDLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= IDLE;
    end else if (sof_hit) begin
      pos_q <= IDX_W'(1);
    end else if (frame_end) begin
      pos_q <= IDLE;
    end else if (sample_en && (pos_q < IDLE)) begin
      pos_q <= pos_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/can_arb_cmp.sv
module can_arb_cmp
  import can_arb_pkg::*;
(
  input  logic      in_win,
  input  logic      muted,
  input  logic      tx_bit,
  input  logic      rx_bit,
  output cmp_kind_e kind
);
  always_comb begin
    kind = CMP_MATCH;
    if (in_win && !muted) begin
      if (tx_bit && !rx_bit) begin
        kind = CMP_LOST;
      end else if (!tx_bit && rx_bit) begin
        kind = CMP_BITERR;
      end
    end
  end
endmodule

// File: rtl/can_arb_state.sv
module can_arb_state
  import can_arb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic             frame_start,
  input  logic             frame_end,
  input  cmp_kind_e        kind,
  input  logic [IDX_W-1:0] pos_cur,
  output logic             lost_q,
  output logic             mute_q,
  output logic             berr_q,
  output logic [IDX_W-1:0] idx_q
);
  logic sof_hit;
  assign sof_hit = sample_en && frame_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      lost_q <= 1'b0;
      mute_q <= 1'b0;
      berr_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (sof_hit) begin
        lost_q <= 1'b0;
        mute_q <= 1'b0;
        berr_q <= 1'b0;
        idx_q  <= '0;
      end else if (frame_end) begin
        mute_q <= 1'b0;
      end
      if (kind == CMP_LOST) begin
        lost_q <= 1'b1;
        mute_q <= 1'b1;
        idx_q  <= pos_cur;
      end else if (kind == CMP_BITERR) begin
        berr_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_arb_monitor.sv
module can_arb_monitor
  import can_arb_pkg::*;
#(
  parameter int ID_W = DEF_ID_W
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  sample_en,
  input  logic                                  frame_start,
  input  logic                                  frame_end,
  input  logic                                  tx_bit,
  input  logic                                  rx_bit,
  output logic                                  tx_out,
  output logic                                  arb_lost,
  output logic                                  rx_only,
  output logic [$clog2(arb_len(ID_W)+1)-1:0]    lost_idx,
  output logic                                  bit_err
);
  localparam int ARB_BITS = arb_len(ID_W);
  localparam int IDX_W    = $clog2(ARB_BITS + 1);

  logic [IDX_W-1:0] pos_cur;
  logic             in_win;
  logic             mute_q;
  logic             mute_now;
  cmp_kind_e        kind;

  can_arb_pos #(.ARB_BITS(ARB_BITS), .IDX_W(IDX_W)) u_pos (
    .clk(clk), .rst(rst), .sample_en(sample_en), .frame_start(frame_start),
    .frame_end(frame_end), .pos_cur(pos_cur), .in_win(in_win)
  );

  // a start-of-frame strobe re-arms comparison even if muted from the last frame
  assign mute_now = mute_q && !(sample_en && frame_start);

  can_arb_cmp u_cmp (
    .in_win(in_win), .muted(mute_now), .tx_bit(tx_bit), .rx_bit(rx_bit), .kind(kind)
  );

  can_arb_state #(.IDX_W(IDX_W)) u_state (
    .clk(clk), .rst(rst), .sample_en(sample_en), .frame_start(frame_start),
    .frame_end(frame_end), .kind(kind), .pos_cur(pos_cur),
    .lost_q(arb_lost), .mute_q(mute_q), .berr_q(bit_err), .idx_q(lost_idx)
  );

  assign rx_only = mute_q;
  assign tx_out  = tx_bit | mute_q;
endmodule

// File: rtl/can_arb_monitor_chk.sv
module can_arb_monitor_chk #(
  parameter int ARB_BITS = 14,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_en,
  input logic             frame_start,
  input logic             frame_end,
  input logic             tx_bit,
  input logic             rx_bit,
  input logic             tx_out,
  input logic             arb_lost,
  input logic             rx_only,
  input logic [IDX_W-1:0] lost_idx,
  input logic             bit_err
);
  AST_LOSS_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> $past(sample_en && tx_bit && !rx_bit)); // R3

  AST_LOSS_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (lost_idx < IDX_W'(ARB_BITS))); // R4

  AST_MUTED_TX_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
    rx_only |-> tx_out); // R5

  AST_LOSS_HELD: assert property (@(posedge clk) disable iff (rst)
    (arb_lost && !(sample_en && frame_start)) |=> (arb_lost && $stable(lost_idx))); // R6

  AST_BITERR_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_err) |-> $past(sample_en && !tx_bit && rx_bit)); // R7

  AST_FRAME_END_UNMUTES: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !(sample_en && frame_start)) |=> !rx_only); // R9
endmodule

bind can_arb_monitor can_arb_monitor_chk #(.ARB_BITS(ARB_BITS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .sample_en(sample_en), .frame_start(frame_start),
  .frame_end(frame_end), .tx_bit(tx_bit), .rx_bit(rx_bit), .tx_out(tx_out),
  .arb_lost(arb_lost), .rx_only(rx_only), .lost_idx(lost_idx), .bit_err(bit_err)
);

// File: tb/tb_can_arb_monitor.sv
`timescale 1ns/1ps
module tb_can_arb_monitor;
  localparam int NB = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
  logic tx_bit = 1'b1, rx_bit = 1'b1;
  logic tx_out, arb_lost, rx_only, bit_err;
  logic [3:0] lost_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  can_arb_monitor dut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .frame_start(frame_start),
    .frame_end(frame_end), .tx_bit(tx_bit), .rx_bit(rx_bit), .tx_out(tx_out),
    .arb_lost(arb_lost), .rx_only(rx_only), .lost_idx(lost_idx), .bit_err(bit_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // bit k of the arbitration window for a given identifier and RTR (IDE sent dominant)
  function automatic bit win_bit(input logic [10:0] id, input bit rtr, input int k);
    if (k == 0) return 1'b0;
    if (k <= 11) return id[11 - k];
    if (k == 12) return rtr;
    return 1'b0;
  endfunction

  task automatic strobe(input bit tx, input bit rx, input bit fs);
    @(negedge clk);
    sample_en = 1'b1; tx_bit = tx; rx_bit = rx; frame_start = fs;
    @(posedge clk);
    #1;
    sample_en = 1'b0; frame_start = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge clk);
    frame_end = 1'b1;
    @(posedge clk);
    #1;
    frame_end = 1'b0;
  endtask

  // two nodes on a wired-AND bus; flip_k forces the bus recessive at that position
  task automatic run_frame(input logic [10:0] oid, input bit ortr,
                           input logic [10:0] xid, input bit xrtr, input int flip_k);
    bit lost = 0, xlost = 0, berr = 0;
    int idx = 0;
    for (int k = 0; k < NB; k++) begin
      bit own = win_bit(oid, ortr, k);
      bit oth = win_bit(xid, xrtr, k);
      bit own_e = lost ? 1'b1 : own;
      bit oth_e = xlost ? 1'b1 : oth;
      bit bus = own_e & oth_e;
      int gap = $urandom_range(0, 2);
      if (k == flip_k) bus = 1'b1;
      for (int g = 0; g < gap; g++) @(negedge clk);
      @(negedge clk);
      sample_en = 1'b1; tx_bit = own; rx_bit = bus; frame_start = (k == 0);
      #1;
      if (lost) check(tx_out === 1'b1, "R5 tx_out forced recessive", tx_out, 1);
      else      check(tx_out === own, "R1 tx_out follows tx_bit", tx_out, own);
      if (!lost) begin
        if (own && !bus) begin lost = 1; idx = k; end
        else if (!own && bus) berr = 1;
      end
      if (oth_e && !bus) xlost = 1;
      @(posedge clk);
      #1;
      sample_en = 1'b0; frame_start = 1'b0;
    end
    // bits past IDE with arbitrary mismatches (R8)
    for (int e = 0; e < 4; e++) strobe($urandom_range(0, 1), $urandom_range(0, 1), 1'b0);
    @(negedge clk);
    check(arb_lost === lost, "R3 arb_lost", arb_lost, lost);
    check(lost_idx === 4'(lost ? idx : 0), "R4 lost_idx", lost_idx, lost ? idx : 0);
    check(bit_err === berr, "R7 bit_err", bit_err, berr);
    check(rx_only === lost, "R5 rx_only", rx_only, lost);
    end_frame();
    @(negedge clk);
    check(rx_only === 1'b0, "R9 rx_only released", rx_only, 0);
    check(arb_lost === lost, "R6 arb_lost held past frame end", arb_lost, lost);
  endtask

  task automatic expect_loss(input logic [10:0] oid, input bit ortr,
                             input logic [10:0] xid, input bit xrtr,
                             input bit exp_lost, input int exp_idx, input string req);
    run_frame(oid, ortr, xid, xrtr, -1);
    check(arb_lost === exp_lost, req, arb_lost, exp_lost);
    if (exp_lost) check(lost_idx === 4'(exp_idx), req, lost_idx, exp_idx);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(arb_lost === 1'b0 && rx_only === 1'b0 && bit_err === 1'b0, "R1 reset flags",
          {arb_lost, rx_only, bit_err}, 0);
    check(lost_idx === 4'd0, "R1 reset lost_idx", lost_idx, 0);
    // no frame yet: mismatching strobe must be ignored
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check(arb_lost === 1'b0 && bit_err === 1'b0, "R1 no compare before frame_start",
          {arb_lost, bit_err}, 0);

    // directed cases (R2, R10)
    expect_loss(11'h400, 0, 11'h000, 0, 1, 1,  "R10 lose at ID10 position 1");
    expect_loss(11'h001, 0, 11'h000, 0, 1, 11, "R10 lose at ID0 position 11");
    expect_loss(11'h123, 1, 11'h123, 0, 1, 12, "R10 remote loses to data at RTR");
    expect_loss(11'h123, 0, 11'h123, 1, 0, 0,  "R10 data beats remote");
    expect_loss(11'h2AA, 0, 11'h2AA, 0, 0, 0,  "R2 identical frames no loss");
    expect_loss(11'h000, 0, 11'h7FF, 1, 0, 0,  "R10 lowest id wins");
    expect_loss(11'h7FF, 1, 11'h000, 0, 1, 1,  "R6 early loss then held");
    // bit error at start-of-frame and at an identifier bit (R7)
    run_frame(11'h000, 0, 11'h7FF, 1, 0);
    check(bit_err === 1'b1 && arb_lost === 1'b0, "R7 bit error at SOF", {bit_err, arb_lost}, 2);
    run_frame(11'h3FF, 0, 11'h3FF, 0, 1);
    check(bit_err === 1'b1, "R7 bit error at ID10", bit_err, 1);

    // after frame_end, mismatches are ignored (R9)
    strobe(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check(rx_only === 1'b0, "R9 no compare after frame_end", rx_only, 0);

    // new frame_start clears previous loss (R9)
    strobe(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check(arb_lost === 1'b0 && lost_idx === 4'd0 && bit_err === 1'b0, "R9 frame_start clears",
          {arb_lost, bit_err}, 0);
    end_frame();

    // random frames (R3, R4, R10)
    for (int f = 0; f < 60; f++) begin
      logic [10:0] a = 11'($urandom);
      logic [10:0] b = ($urandom_range(0, 3) == 0) ? a : 11'($urandom);
      run_frame(a, $urandom_range(0, 1), b, $urandom_range(0, 1), -1);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule